// File: doc/BRIEF.md
# Counter Carry Lookahead Tree

This block is the combinational carry network for a binary counter of parameterised width. Each counter bit supplies one propagate flag, which is high when that bit holds a one. The block returns, for every bit position, an active-low flag that says whether a carry arrives at that bit. It also returns a single carry-out for the whole counter, which is enabled by a counter-level carry-enable input. The counter flops and the per-bit toggle cells sit outside the block.

The network is a radix-2 tree. Each level merges neighbouring groups in pairs until two groups remain. A root cell then closes the tree. When a level has an odd number of groups, the leftover group on the least significant side passes through a one-input cell. The logic sense of the signals flips at every level, as it would in a tree of inverting gates. The least significant counter bit sits at the highest index, and carries travel from the high indices toward index 0. The carry-enable input only gates the final carry-out. The per-bit carries never depend on it.

Top module: `cnt_lookahead_tree`

## Requirements
- R1: For every index i, `carry_n_o[i]` is low exactly when every `prop_i` bit at an index greater than i is high. Index WIDTH-1 is the least significant bit.
- R2: `carry_n_o[WIDTH-1]`, the least significant position, is low for every input pattern.
- R3: `carry_out_o` is high exactly when `carry_en_i` is high and all WIDTH `prop_i` bits are high.
- R4: `carry_en_i` has no effect on `carry_n_o`. For the same `prop_i`, both values of `carry_en_i` give the same `carry_n_o`.
- R5: R1 to R3 hold for every WIDTH of 2 or more, including widths that are not powers of two. At those widths a level has a leftover group that goes through a one-input cell.
- R6: The block holds no state. The outputs are a function of the present inputs only, and they are valid in the same cycle the inputs are applied.
- R7: A WIDTH below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prop_i | input | WIDTH | Per-bit propagate flags, high when the counter bit is one; index WIDTH-1 is the LSB |
| carry_en_i | input | 1 | Counter carry-enable; gates only `carry_out_o` |
| carry_n_o | output | WIDTH | Active-low carry into each bit position |
| carry_out_o | output | 1 | Carry out of the whole counter, active high |

## Verification
The assertions are evaluated combinationally, and they are skipped while any input carries an unknown value. They therefore assume that the inputs are fully driven whenever the outputs matter. The bench drives every input from a known value before the first sample. It changes inputs only on the falling clock edge, so the network has settled by the time it is checked. It covers widths 2, 3, 5, 7, 13 and 16 with one shared stimulus word, sliced to each width. This runs exhaustively up to width 7 and randomly above that.

// File: rtl/cnt_lookahead_pkg.sv
package cnt_lookahead_pkg;

   // Number of groups entering level k of a tree over n bits.
   function automatic int lvl_size(input int n, input int k);
      int s;
      s = n;
      for (int i = 0; i < k; i++) s = (s + 1) / 2;
      return s;
   endfunction

   // Number of pairing levels before the root; a level exists while size > 2.
   function automatic int lvl_count(input int n);
      int s;
      int c;
      s = n;
      c = 0;
      while (s > 2) begin
         s = (s + 1) / 2;
         c++;
      end
      return c;
   endfunction

   // Offset of level k inside the flattened per-level signal vectors.
   function automatic int lvl_offset(input int n, input int k);
      int o;
      o = 0;
      for (int i = 0; i < k; i++) o += lvl_size(n, i);
      return o;
   endfunction

endpackage

// File: rtl/cnt_la_pair.sv
// Two-input merge cell. Inputs arrive in sense POS (1 = active high),
// merged propagate and per-input carries leave in the opposite sense.
// The carry from the next level arrives in sense POS as well.
module cnt_la_pair #(
   parameter bit POS = 1'b1
) (
   input  logic p_hi_i,   // more significant group (lower index)
   input  logic p_lo_i,   // less significant group (higher index)
   input  logic c_i,      // carry into the merged group
   output logic p_o,
   output logic c_hi_o,
   output logic c_lo_o
);
   logic ph, pl, cc;
   logic pm, ch, cl;

   assign ph = POS ? p_hi_i : ~p_hi_i;
   assign pl = POS ? p_lo_i : ~p_lo_i;
   assign cc = POS ? c_i    : ~c_i;

   assign pm = ph & pl;
   assign cl = cc;
   assign ch = cc & pl;

   assign p_o    = POS ? ~pm : pm;
   assign c_hi_o = POS ? ~ch : ch;
   assign c_lo_o = POS ? ~cl : cl;
endmodule

// File: rtl/cnt_la_single.sv
// One-input cell for a leftover group: logically a pass-through, but the
// level sense flips, so both directions are inverted physically.
module cnt_la_single (
   input  logic p_i,
   input  logic c_i,
   output logic p_o,
   output logic c_o
);
   assign p_o = ~p_i;
   assign c_o = ~c_i;
endmodule

// File: rtl/cnt_la_root.sv
// Closing cell over the last two groups. Carry into the least significant
// group is forced on; the enable only gates the counter carry-out.
module cnt_la_root #(
   parameter bit POS = 1'b1
) (
   input  logic p_hi_i,
   input  logic p_lo_i,
   input  logic en_i,
   output logic c_hi_o,
   output logic c_lo_o,
   output logic cout_o
);
   logic ph, pl;

   assign ph = POS ? p_hi_i : ~p_hi_i;
   assign pl = POS ? p_lo_i : ~p_lo_i;

   assign c_lo_o = POS ? 1'b0 : 1'b1;
   assign c_hi_o = POS ? ~pl : pl;
   assign cout_o = en_i & ph & pl;
endmodule

// File: rtl/cnt_lookahead_tree.sv
module cnt_lookahead_tree
   import cnt_lookahead_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] prop_i,
   input  logic             carry_en_i,
   output logic [WIDTH-1:0] carry_n_o,
   output logic             carry_out_o
);
   // R7: reject degenerate widths at elaboration
   if (WIDTH < 2) begin : g_width_chk
      $error("cnt_lookahead_tree: WIDTH must be at least 2");
   end

   localparam int LEVELS = lvl_count(WIDTH);
   localparam int TOTAL  = lvl_offset(WIDTH, LEVELS + 1);
   localparam int ROFF   = lvl_offset(WIDTH, LEVELS);
   localparam bit RPOS   = (LEVELS % 2) == 0;

   // Flattened per-level vectors: level k occupies [OFF +: SZ].
   logic [TOTAL-1:0] pv;
   logic [TOTAL-1:0] cv;

   assign pv[WIDTH-1:0] = prop_i;
   assign carry_n_o     = cv[WIDTH-1:0];

   for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
      localparam int SZ   = lvl_size(WIDTH, k);
      localparam int BLK  = (SZ + 1) / 2;
      localparam int OFF  = lvl_offset(WIDTH, k);
      localparam int NOFF = lvl_offset(WIDTH, k + 1);
      localparam bit POS  = (k % 2) == 0;

      for (genvar j = 0; j < BLK; j++) begin : g_cell
         if (2 * j == SZ - 1) begin : g_single
            cnt_la_single u_single (
               .p_i (pv[OFF + 2*j]),
               .c_i (cv[NOFF + j]),
               .p_o (pv[NOFF + j]),
               .c_o (cv[OFF + 2*j])
            );
         end else begin : g_pair
            cnt_la_pair #(.POS(POS)) u_pair (
               .p_hi_i (pv[OFF + 2*j]),
               .p_lo_i (pv[OFF + 2*j + 1]),
               .c_i    (cv[NOFF + j]),
               .p_o    (pv[NOFF + j]),
               .c_hi_o (cv[OFF + 2*j]),
               .c_lo_o (cv[OFF + 2*j + 1])
            );
         end
      end
   end

   cnt_la_root #(.POS(RPOS)) u_root (
      .p_hi_i (pv[ROFF]),
      .p_lo_i (pv[ROFF + 1]),
      .en_i   (carry_en_i),
      .c_hi_o (cv[ROFF]),
      .c_lo_o (cv[ROFF + 1]),
      .cout_o (carry_out_o)
   );
endmodule

// File: rtl/cnt_lookahead_chk.sv
module cnt_lookahead_chk #(
   parameter int WIDTH = 16
) (
   input logic [WIDTH-1:0] prop_i,
   input logic             carry_en_i,
   input logic [WIDTH-1:0] carry_n_o,
   input logic             carry_out_o
);
   always_comb begin
      if (!$isunknown({prop_i, carry_en_i})) begin
         // R2: least significant position always receives a carry
         a_r2_lsb_carry: assert (carry_n_o[WIDTH-1] == 1'b0);
         // R1: carry into i follows carry into i+1 gated by propagate of i+1
         for (int i = 0; i < WIDTH - 1; i++) begin
            a_r1_chain: assert ((!carry_n_o[i]) == ((!carry_n_o[i+1]) && prop_i[i+1]));
         end
         // R3: carry-out needs the enable and all bits propagating
         a_r3_cout: assert (carry_out_o == (carry_en_i && (&prop_i)));
         // R3: carry-out implies a carry reaches every position
         a_r3_cout_all: assert (!carry_out_o || (carry_n_o == '0));
      end
   end
endmodule

bind cnt_lookahead_tree cnt_lookahead_chk #(.WIDTH(WIDTH)) u_chk (
   .prop_i      (prop_i),
   .carry_en_i  (carry_en_i),
   .carry_n_o   (carry_n_o),
   .carry_out_o (carry_out_o)
);

// File: tb/tb_cnt_lookahead_tree.sv
module tb_cnt_lookahead_tree;
   localparam int CLK_PERIOD = 10;
   localparam int MAXW = 16;

   typedef struct {
      int              w;
      logic [MAXW-1:0] exp_n;
      logic            exp_c;
      string           tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [MAXW-1:0] stim_p = '0;
   logic stim_en = 1'b0;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [15:0] n16; logic c16;
   logic [12:0] n13; logic c13;
   logic [6:0]  n7;  logic c7;
   logic [4:0]  n5;  logic c5;
   logic [2:0]  n3;  logic c3;
   logic [1:0]  n2;  logic c2;

   cnt_lookahead_tree #(.WIDTH(16)) dut (
      .prop_i(stim_p[15:0]), .carry_en_i(stim_en), .carry_n_o(n16), .carry_out_o(c16));
   cnt_lookahead_tree #(.WIDTH(13)) dut_w13 (
      .prop_i(stim_p[12:0]), .carry_en_i(stim_en), .carry_n_o(n13), .carry_out_o(c13));
   cnt_lookahead_tree #(.WIDTH(7)) dut_w7 (
      .prop_i(stim_p[6:0]), .carry_en_i(stim_en), .carry_n_o(n7), .carry_out_o(c7));
   cnt_lookahead_tree #(.WIDTH(5)) dut_w5 (
      .prop_i(stim_p[4:0]), .carry_en_i(stim_en), .carry_n_o(n5), .carry_out_o(c5));
   cnt_lookahead_tree #(.WIDTH(3)) dut_w3 (
      .prop_i(stim_p[2:0]), .carry_en_i(stim_en), .carry_n_o(n3), .carry_out_o(c3));
   cnt_lookahead_tree #(.WIDTH(2)) dut_w2 (
      .prop_i(stim_p[1:0]), .carry_en_i(stim_en), .carry_n_o(n2), .carry_out_o(c2));

   // Ripple reference for R1/R2: carry into i needs every index above i propagating.
   function automatic logic [MAXW-1:0] ref_n(input int w, input logic [MAXW-1:0] p);
      logic [MAXW-1:0] r;
      r = '0;
      for (int i = 0; i < w; i++) begin
         logic cy;
         cy = 1'b1;
         for (int j = w - 1; j > i; j--) cy = cy & p[j];
         r[i] = ~cy;
      end
      return r;
   endfunction

   // R3 reference
   function automatic logic ref_c(input int w, input logic [MAXW-1:0] p, input logic en);
      logic a;
      a = en;
      for (int j = 0; j < w; j++) a = a & p[j];
      return a;
   endfunction

   task automatic chk(input bit ok, input string tag, input int w,
                      input logic [MAXW-1:0] act, input logic [MAXW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s width=%0d actual=%h expected=%h", tag, w, act, exp);
      end
   endtask

   // Driver: applies stimulus on the falling edge and queues expectations
   // for every width instance.
   task automatic apply(input logic [MAXW-1:0] p, input logic en, input string base);
      int wl[6] = '{2, 3, 5, 7, 13, 16};
      @(negedge clk);
      stim_p  = p;
      stim_en = en;
      foreach (wl[k]) begin
         exp_t it;
         it.w     = wl[k];
         it.exp_n = ref_n(wl[k], p);
         it.exp_c = ref_c(wl[k], p, en);
         // R5: non-power-of-two widths exercise the one-input cells
         it.tag   = ((wl[k] & (wl[k] - 1)) != 0) ? {base, "/R5"} : base;
         q.push_back(it);
      end
   endtask

   // Monitor: sampled at the rising edge, half a cycle after the inputs
   // changed; R6 requires the outputs to be valid there with no state.
   always @(posedge clk) begin
      if (!rst) begin
         while (q.size() > 0) begin
            exp_t it;
            logic [MAXW-1:0] gn;
            logic gc;
            it = q.pop_front();
            gn = '0;
            gc = 1'b0;
            case (it.w)
               2:  begin gn[1:0]  = n2;  gc = c2;  end
               3:  begin gn[2:0]  = n3;  gc = c3;  end
               5:  begin gn[4:0]  = n5;  gc = c5;  end
               7:  begin gn[6:0]  = n7;  gc = c7;  end
               13: begin gn[12:0] = n13; gc = c13; end
               default: begin gn = n16; gc = c16; end
            endcase
            chk(gn == it.exp_n, {it.tag, " carries R1 R6"}, it.w, gn, it.exp_n);
            chk(gn[it.w-1] == 1'b0, {it.tag, " lsb R2"}, it.w, {15'b0, gn[it.w-1]}, '0);
            chk(gc == it.exp_c, {it.tag, " cout R3"}, it.w, {15'b0, gc}, {15'b0, it.exp_c});
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Initial state: nothing propagating, enable off (R2)
      apply('0, 1'b0, "R2");
      // Exhaustive over the low 8 bits, both enables: covers widths 2..7 fully
      for (int v = 0; v < 256; v++) begin
         apply({8'h00, v[7:0]}, 1'b1, "R1");
         apply({8'h00, v[7:0]}, 1'b0, "R3");
      end
      // Directed corners: all ones with and without enable, LSB-only, all but LSB
      apply('1, 1'b1, "R3");
      apply('1, 1'b0, "R3");
      apply(16'h8000, 1'b1, "R1");
      apply(16'h7FFF, 1'b1, "R1");
      apply(16'h1FFF, 1'b1, "R3");
      // R4: the same pattern with enable toggled must give identical carries
      for (int n = 0; n < 150; n++) begin
         logic [MAXW-1:0] r;
         r = MAXW'($urandom);
         if (n % 5 == 0) r = r | 16'hFFF0;
         apply(r, 1'b0, "R4");
         apply(r, 1'b1, "R4");
      end
      // Random sweep with long propagate runs on the LSB side
      for (int n = 0; n < 300; n++) begin
         logic [MAXW-1:0] r;
         r = MAXW'($urandom);
         if (n % 3 == 0) r = r | (16'hFFFF >> (n % 16));
         if (n % 7 == 0) r = r | (16'hFFFF << (n % 16));
         apply(r, n[0], "R1");
      end
      @(posedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog R6 actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule